// File: doc/BRIEF.md
# Head Stepper Phase Sequencer with Hold-Current Reduction

This block drives the four phase windings of a head-positioning stepper motor. At rest it sits in a hold state with only phase 4 energised. A step request starts one stepping cycle. The request is taken on the falling edge of the step input, and only while the drive is selected, no write is in progress and power is good. During the cycle the block walks through four timed positions. The winding order follows the direction that was captured when the step was accepted, and every cycle finishes on phase 4.

A busy flag stays high for the whole cycle. It gates the write enable, so no write can start while the head is moving. Every accepted step also restarts an idle timer and selects full hold current. If the timer runs out before another step is accepted, the block selects reduced, roughly half, hold current. All timing counts ticks of a clock enable, nominally 1 kHz. With the default values the cycle lasts 23 ms, and reduction follows 35 ms after the step.

The controller has five states:
- `ST_IDLE` is the hold state.
- `ST_SEQ0`, `ST_SEQ1` and `ST_SEQ2` each last `PHASE_TICKS` ticks.
- `ST_SEQ3` lasts `LAST_TICKS` ticks.

The transitions are:
- `ST_IDLE` to `ST_SEQ0` on an accepted step.
- `ST_SEQ0` to `ST_SEQ1`, and `ST_SEQ1` to `ST_SEQ2`, when the dwell count expires.
- `ST_SEQ2` to `ST_SEQ3` when the dwell count expires.
- `ST_SEQ3` back to `ST_IDLE` when its own count expires.

Top module: `head_step_seq`

## Requirements
- R1: After reset, `phase` is 4'b1000 (phase 4 only), `busy` is low and `hold_full` is low (reduced hold).
- R2: Whenever `busy` is low, `phase` equals 4'b1000.
- R3: A step is accepted when `step_in` is low at a clock edge after being high at the previous edge, with `sel`=1, `wr_en`=0 and `pwr_ok`=1 sampled at that same edge. After the next clock edge, `busy` is high and the first phase of the sequence is driven. Any other condition leaves the block idle.
- R4: When the latched direction is 0 (step-in), the four cycle positions drive phase bits 0, 1, 2, 3 in that order (phase 1, 2, 3, 4). Bit n of `phase` is phase n+1.
- R5: When the latched direction is 1 (step-out), the positions drive phase bits 2, 1, 0, 3 (phase 3, 2, 1, 4).
- R6: The first three positions each last `PHASE_TICKS` ticks and the last position lasts `LAST_TICKS` ticks. `busy` falls on the edge that consumes the final tick.
- R7: `busy` is high for the whole cycle. `wr_allow` equals `wr_en` while `busy` is low and is 0 while `busy` is high.
- R8: Step edges that occur while `busy` is high are ignored. The running sequence and its timing do not change.
- R9: `dir` is captured when the step is accepted. Changing `dir` during a cycle does not alter that cycle's order.
- R10: An accepted step sets `hold_full` to 1 on the acceptance edge. It drops to 0 on the edge that consumes the `HOLD_TIMEOUT`-th tick counted from acceptance, unless another step is accepted first.
- R11: Exactly one bit of `phase` is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timing enable (nominally 1 kHz) |
| step_in | input | 1 | Step request; acts on its falling edge |
| dir | input | 1 | 0 = step in, 1 = step out |
| sel | input | 1 | Drive selected |
| wr_en | input | 1 | Write request from the host |
| pwr_ok | input | 1 | Supply good |
| phase | output | 4 | Winding enables; bit n is phase n+1 |
| busy | output | 1 | Stepping cycle in progress |
| wr_allow | output | 1 | Write enable gated by busy |
| hold_full | output | 1 | 1 = full hold current, 0 = reduced |

## Verification
The bench fires a second step in the middle of a cycle. A design that restarted the cycle would repeat the first phase or stretch the busy time. It also flips `dir` during a cycle, which catches an order decoded from the live input instead of the latched one.

The hold timer is checked on the tick just before the timeout and on the timeout tick. An off-by-one counter drops the current one tick early or late. Steps refused for each qualifier must leave both busy and the hold level untouched. A design that let the timer restart on a refused step would keep full current too long. Random step and idle-gap sequences then compare every position and the hold level against a bench model.

// File: rtl/hsq_pkg.sv
package hsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEQ0 = 3'd1,
        ST_SEQ1 = 3'd2,
        ST_SEQ2 = 3'd3,
        ST_SEQ3 = 3'd4
    } hsq_state_e;

    localparam logic [3:0] HOLD_PHASE = 4'b1000;

endpackage

// File: rtl/hsq_step_qual.sv
module hsq_step_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic step_in,
    input  logic sel,
    input  logic wr_en,
    input  logic pwr_ok,
    input  logic busy,
    output logic accept
);
    logic step_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) step_prev <= 1'b0;
        else        step_prev <= step_in;
    end

    // trailing edge of the step pulse, qualified by drive conditions
    always_comb begin
        accept = step_prev && !step_in && sel && !wr_en && pwr_ok && !busy;
    end
endmodule

// File: rtl/hsq_phase_map.sv
module hsq_phase_map
    import hsq_pkg::*;
(
    input  hsq_state_e state,
    input  logic       dir_q,
    output logic [3:0] phase
);
    always_comb begin
        phase = HOLD_PHASE;
        unique case (state)
            ST_IDLE: phase = HOLD_PHASE;
            ST_SEQ0: phase = dir_q ? 4'b0100 : 4'b0001;
            ST_SEQ1: phase = 4'b0010;
            ST_SEQ2: phase = dir_q ? 4'b0001 : 4'b0100;
            ST_SEQ3: phase = HOLD_PHASE;
            default: phase = HOLD_PHASE;
        endcase
    end
endmodule

// File: rtl/hsq_hold_timer.sv
module hsq_hold_timer #(
    parameter int HOLD_TIMEOUT = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic hold_full
);
    localparam int AW = $clog2(HOLD_TIMEOUT + 1);
    localparam logic [AW-1:0] AGE_LAST = AW'(HOLD_TIMEOUT - 1);

    logic [AW-1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age       <= '0;
            hold_full <= 1'b0;
        end else if (restart) begin
            age       <= '0;
            hold_full <= 1'b1;
        end else if (tick && hold_full) begin
            if (age == AGE_LAST) begin
                age       <= '0;
                hold_full <= 1'b0;
            end else begin
                age <= age + 1'b1;
            end
        end
    end
endmodule

// File: rtl/head_step_seq.sv
module head_step_seq
    import hsq_pkg::*;
#(
    parameter int PHASE_TICKS  = 6,
    parameter int LAST_TICKS   = 5,
    parameter int HOLD_TIMEOUT = 35
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       step_in,
    input  logic       dir,
    input  logic       sel,
    input  logic       wr_en,
    input  logic       pwr_ok,
    output logic [3:0] phase,
    output logic       busy,
    output logic       wr_allow,
    output logic       hold_full
);
    localparam int MAXD = (PHASE_TICKS > LAST_TICKS) ? PHASE_TICKS : LAST_TICKS;
    localparam int CW   = $clog2(MAXD + 1);
    localparam logic [CW-1:0] PH_END   = CW'(PHASE_TICKS - 1);
    localparam logic [CW-1:0] LAST_END = CW'(LAST_TICKS - 1);

    hsq_state_e    state_q, state_d;
    logic [CW-1:0] dwell_q;
    logic          dir_q;
    logic          accept;
    logic          dwell_done;

    hsq_step_qual u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_in (step_in),
        .sel     (sel),
        .wr_en   (wr_en),
        .pwr_ok  (pwr_ok),
        .busy    (busy),
        .accept  (accept)
    );

    hsq_hold_timer #(.HOLD_TIMEOUT(HOLD_TIMEOUT)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .restart   (accept),
        .hold_full (hold_full)
    );

    hsq_phase_map u_map (
        .state (state_q),
        .dir_q (dir_q),
        .phase (phase)
    );

    always_comb begin
        dwell_done = tick && (dwell_q == ((state_q == ST_SEQ3) ? LAST_END : PH_END));
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)     state_d = ST_SEQ0;
            ST_SEQ0: if (dwell_done) state_d = ST_SEQ1;
            ST_SEQ1: if (dwell_done) state_d = ST_SEQ2;
            ST_SEQ2: if (dwell_done) state_d = ST_SEQ3;
            ST_SEQ3: if (dwell_done) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register, dwell counter, latched direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dwell_q <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                dwell_q <= '0;
                dir_q   <= dir;
            end else if (state_q != ST_IDLE && tick) begin
                dwell_q <= dwell_done ? '0 : dwell_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        wr_allow = wr_en && !busy;
    end
endmodule

// File: rtl/hsq_checker.sv
module hsq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       step_in,
    input logic       sel,
    input logic       wr_en,
    input logic       pwr_ok,
    input logic [3:0] phase,
    input logic       busy,
    input logic       wr_allow,
    input logic       hold_full
);
    a_r11_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1);

    a_r2_idle_phase4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> phase == 4'b1000);

    a_r7_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_allow);

    a_r10_full_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> hold_full);

    a_r3_start_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(sel) && !$past(wr_en) && $past(pwr_ok) && !$past(step_in)));

    a_r6_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick));
endmodule

bind head_step_seq hsq_checker u_hsq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .step_in   (step_in),
    .sel       (sel),
    .wr_en     (wr_en),
    .pwr_ok    (pwr_ok),
    .phase     (phase),
    .busy      (busy),
    .wr_allow  (wr_allow),
    .hold_full (hold_full)
);

// File: tb/head_step_seq_test.sv
module head_step_seq_test;
    localparam int PT = 3;
    localparam int LT = 2;
    localparam int TO = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, step_in = 1'b0, dir = 1'b0, sel = 1'b0, wr_en = 1'b0, pwr_ok = 1'b0;
    logic [3:0] phase;
    logic busy, wr_allow, hold_full;

    int checks = 0;
    int errors = 0;
    int age_m = 0;
    bit hold_m = 1'b0;

    always #2.5 clk = ~clk;

    head_step_seq #(.PHASE_TICKS(PT), .LAST_TICKS(LT), .HOLD_TIMEOUT(TO)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .step_in(step_in), .dir(dir),
        .sel(sel), .wr_en(wr_en), .pwr_ok(pwr_ok), .phase(phase),
        .busy(busy), .wr_allow(wr_allow), .hold_full(hold_full)
    );

    function automatic logic [3:0] exp_phase(input bit d, input int k);
        if (k == 3) return 4'b1000;
        if (!d) return 4'(1 << k);
        return 4'(1 << (2 - k));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick1();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        if (hold_m) begin
            age_m++;
            if (age_m >= TO) hold_m = 1'b0;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick1();
    endtask

    // one step pulse; returns whether the model expects acceptance
    task automatic do_step(input bit s, input bit w, input bit p, input bit d, output bit acc);
        bit was_busy;
        @(negedge clk);
        was_busy = busy;
        sel = s; wr_en = w; pwr_ok = p; dir = d; step_in = 1'b1;
        @(negedge clk) step_in = 1'b0;
        @(negedge clk);
        acc = s && !w && p && !was_busy;
        if (acc) begin
            hold_m = 1'b1;
            age_m = 0;
        end
    endtask

    // walk one full cycle, checking every position
    task automatic run_cycle(input bit d, input bit poke);
        bit dummy;
        for (int k = 0; k < 4; k++) begin
            chk(phase == exp_phase(d, k), d ? "R5 step-out order" : "R4 step-in order", phase, exp_phase(d, k));
            chk(busy == 1'b1, "R7 busy during cycle", busy, 1);
            chk(hold_full == 1'b1, "R10 full hold while busy", hold_full, 1);
            if (poke && k == 1) begin
                do_step(1'b1, 1'b0, 1'b1, ~d, dummy);
                chk(phase == exp_phase(d, 1), "R8 step while busy ignored", phase, exp_phase(d, 1));
                chk(dummy == 1'b0, "R8 model", dummy, 0);
                @(negedge clk) wr_en = 1'b1;
                @(negedge clk);
                chk(wr_allow == 1'b0, "R7 write gated while busy", wr_allow, 0);
                wr_en = 1'b0;
            end
            if (k == 0) dir = ~d;   // R9: live direction change
            ticks(k == 3 ? LT : PT);
        end
        chk(busy == 1'b0, "R6 busy ends after last dwell", busy, 0);
        chk(phase == 4'b1000, "R2 hold phase after cycle", phase, 4'b1000);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit acc;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(phase == 4'b1000, "R1 reset phase", phase, 4'b1000);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        chk(hold_full == 1'b0, "R1 reset hold reduced", hold_full, 0);
        wr_en = 1'b1;
        @(negedge clk);
        chk(wr_allow == 1'b1, "R7 write passes when idle", wr_allow, 1);
        wr_en = 1'b0;

        // refused steps
        do_step(1'b0, 1'b0, 1'b1, 1'b0, acc);
        chk(busy == 1'b0 && hold_full == 1'b0, "R3 refused when deselected", {busy, hold_full}, 0);
        do_step(1'b1, 1'b1, 1'b1, 1'b0, acc);
        chk(busy == 1'b0 && hold_full == 1'b0, "R3 refused when writing", {busy, hold_full}, 0);
        do_step(1'b1, 1'b0, 1'b0, 1'b0, acc);
        chk(busy == 1'b0 && hold_full == 1'b0, "R3 refused without power", {busy, hold_full}, 0);

        // step-in with mid-cycle poke
        do_step(1'b1, 1'b0, 1'b1, 1'b0, acc);
        chk(busy == 1'b1, "R3 accepted step starts cycle", busy, 1);
        run_cycle(1'b0, 1'b1);

        // hold timeout boundary: PT*3+LT ticks already used
        ticks(TO - (3 * PT + LT) - 1);
        chk(hold_full == 1'b1, "R10 full one tick before timeout", hold_full, 1);
        tick1();
        chk(hold_full == 1'b0, "R10 reduced at timeout", hold_full, 0);

        // step-out
        do_step(1'b1, 1'b0, 1'b1, 1'b1, acc);
        run_cycle(1'b1, 1'b0);
        // new step before timeout restarts full hold
        ticks(1);
        do_step(1'b1, 1'b0, 1'b1, 1'b0, acc);
        run_cycle(1'b0, 1'b0);
        ticks(TO - (3 * PT + LT) - 1);
        chk(hold_full == 1'b1, "R10 timer restarted by new step", hold_full, 1);

        // random mix
        for (int it = 0; it < 60; it++) begin
            bit s, w, p, d;
            s = ($urandom % 5) != 0;
            w = ($urandom % 5) == 0;
            p = ($urandom % 6) != 0;
            d = $urandom % 2;
            do_step(s, w, p, d, acc);
            if (acc) run_cycle(d, ($urandom % 4) == 0);
            else chk(busy == 1'b0, "R3 random refusal", busy, 0);
            ticks($urandom % 12);
            chk(hold_full == hold_m, "R10 random hold level", hold_full, hold_m);
            chk(phase == 4'b1000, "R2 random idle phase", phase, 4'b1000);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule